// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time: seconds, minutes, hours, day of month, weekday, month and a two-digit year. All fields except the weekday are held in packed BCD. A prescaler counts cycles of the slow reference clock and gives one tick per second. Each tick moves the calendar forward one second, and a carry runs up through the fields. Month length and leap years are handled in the carry chain.

Software uses one byte-wide register port. A control byte at address 0 has two bits: one stops the clock, and one stores the crystal load choice. The seven time fields sit at consecutive addresses from 4 upward. Bit 7 of the seconds byte is a sticky flag that marks the time as untrustworthy. The host raises `hold` for the length of a multi-byte read, so the values it collects all belong to the same second. A tick that arrives during the hold is kept and applied as soon as the hold ends.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the seconds, minutes, hours, weekday and year read 0, the day and month read 0x01, the control byte reads 0x00 and the invalid-time flag is 1. The seconds address therefore reads 0x80.
- R2: The address map is as follows.
  - Address 0 is control.
  - Addresses 4..10 hold seconds, minutes, hours, day, weekday, month and year, in that order.
  - Fields keep 7, 7, 6, 6, 3, 5 and 8 bits respectively, so for example a write of 0xE3 to hours reads back 0x23.
  - Bits a field does not keep read 0.
  - Addresses 1..3 and 11..15 read 0x00 and ignore writes.
- R3: `rd_data` shows the addressed register on the cycle after `rd_en` is sampled, and holds its value while `rd_en` is low.
- R4: While the clock runs, the calendar advances exactly once every `DIV_COUNT` cycles.
- R5: Bit 5 of control (1 = stopped) holds the prescaler at zero, and time does not advance. After the bit is cleared, the first advance comes `DIV_COUNT` cycles after the clearing write.
- R6: Bit 0 of control is stored and read back, and it has no effect on counting.
- R7: Bit 7 of the seconds byte is set by reset and takes the value of bit 7 of every seconds write. Ticks never change it.
- R8: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day.
- R9: The day wraps to 01 after 31, 30 or 28 according to the month. February goes to 29 when the year is divisible by 4.
- R10: The weekday (binary 0..6) advances with each day carry and wraps from 6 to 0.
- R11: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R12: While `hold` is high the time fields do not change. One tick seen during the hold is applied on the first clock edge with `hold` low.
- R13: A write to any time field on the same cycle as a tick delays that tick's advance until after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock driving prescaler and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | High for the duration of a multi-byte read burst |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; data appears next cycle |
| rd_data | output | 8 | Registered read data |

## Verification
A behavioural model with plain binary counters predicts every read, and reads issued on every idle cycle compare the design against it, so the exact cycle of each advance is checked.

The calendar is preset just below each boundary and then released:
- the end of a century distinguishes the full carry chain from a partial one;
- February in a leap year and in a common year distinguishes the leap rule;
- a thirty-day month and a mid-month date distinguish month lengths from a fixed wrap.

Separate patterns cover the remaining behaviour:
- a hold of exactly one tick period shows whether a tick is lost, applied early or applied twice;
- a run of back-to-back field writes shows whether a tick that coincides with a write is deferred or dropped.

// File: rtl/tk_pkg.sv
package tk_pkg;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [5:0] day;
      logic [2:0] wday;
      logic [4:0] mon;
      logic [7:0] year;
   } tk_time_t;

   localparam int unsigned TK_FIELDS = 7;

   // next BCD value of a two-digit number (caller handles the wrap point)
   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // last valid day (BCD) of a month, leap rule: binary year divisible by 4
   function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] year);
      logic [6:0] ybin;
      ybin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
      case (mon)
         5'h02:                      return (ybin[1:0] == 2'b00) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
   parameter int DIV_COUNT = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_reset,
   output logic tick
);
   localparam int CNT_W = $clog2(DIV_COUNT);
   localparam bit IS_POW2 = (DIV_COUNT & (DIV_COUNT - 1)) == 0;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_COUNT - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (DIV_COUNT < 2) begin : g_bad_div
         $error("tk_prescaler: DIV_COUNT must be at least 2");
      end

      if (IS_POW2) begin : g_wrap
         // natural binary wrap, no terminal compare in the next-state path
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q <= '0;
            else if (hold_reset) cnt_q <= '0;
            else                 cnt_q <= cnt_q + CNT_W'(1);
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (hold_reset)     cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + CNT_W'(1);
         end
         AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST) else $error("prescaler out of range"); // R4
      end
   endgenerate

   assign tick = !hold_reset && (cnt_q == LAST);

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick) else $error("tick wider than one cycle"); // R4
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hold_reset |=> (cnt_q == '0)) else $error("prescaler ran while stopped"); // R5

endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
   import tk_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 freeze,
   input  logic [TK_FIELDS-1:0] fld_wr,
   input  logic [7:0]           wr_data,
   output tk_time_t             now
);
   tk_time_t t_q, nxt;
   logic     pend_q, any_wr, step;
   logic [7:0] s_inc, m_inc, h_inc, d_inc, mo_inc, y_inc;
   logic     c_min, c_hour, c_day, c_mon, c_year;

   assign any_wr = |fld_wr;
   assign step   = (tick || pend_q) && !freeze && !any_wr;

   assign s_inc  = bcd_next({1'b0, t_q.sec});
   assign m_inc  = bcd_next({1'b0, t_q.min});
   assign h_inc  = bcd_next({2'b00, t_q.hour});
   assign d_inc  = bcd_next({2'b00, t_q.day});
   assign mo_inc = bcd_next({3'b000, t_q.mon});
   assign y_inc  = bcd_next(t_q.year);

   // carry chain: each stage carries only when every lower stage wraps
   assign c_min  = (t_q.sec  == 7'h59);
   assign c_hour = c_min  && (t_q.min  == 7'h59);
   assign c_day  = c_hour && (t_q.hour == 6'h23);
   assign c_mon  = c_day  && (t_q.day  == month_last(t_q.mon, t_q.year));
   assign c_year = c_mon  && (t_q.mon  == 5'h12);

   always_comb begin
      nxt      = t_q;
      nxt.sec  = c_min ? 7'h00 : s_inc[6:0];
      if (c_min)  nxt.min  = (t_q.min == 7'h59) ? 7'h00 : m_inc[6:0];
      if (c_hour) nxt.hour = (t_q.hour == 6'h23) ? 6'h00 : h_inc[5:0];
      if (c_day) begin
         nxt.day  = c_mon ? 6'h01 : d_inc[5:0];
         nxt.wday = (t_q.wday == 3'd6) ? 3'd0 : t_q.wday + 3'd1;
      end
      if (c_mon)  nxt.mon  = (t_q.mon == 5'h12) ? 5'h01 : mo_inc[4:0];
      if (c_year) nxt.year = (t_q.year == 8'h99) ? 8'h00 : y_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q    <= '{sec: 7'h00, min: 7'h00, hour: 6'h00, day: 6'h01,
                     wday: 3'd0, mon: 5'h01, year: 8'h00};
         pend_q <= 1'b0;
      end else begin
         pend_q <= (tick || pend_q) && (freeze || any_wr);
         if (any_wr) begin
            if (fld_wr[0]) t_q.sec  <= wr_data[6:0];
            if (fld_wr[1]) t_q.min  <= wr_data[6:0];
            if (fld_wr[2]) t_q.hour <= wr_data[5:0];
            if (fld_wr[3]) t_q.day  <= wr_data[5:0];
            if (fld_wr[4]) t_q.wday <= wr_data[2:0];
            if (fld_wr[5]) t_q.mon  <= wr_data[4:0];
            if (fld_wr[6]) t_q.year <= wr_data;
         end else if (step) begin
            t_q <= nxt;
         end
      end
   end

   assign now = t_q;

   AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !any_wr) |=> $stable(t_q)) else $error("time moved during hold"); // R12
   AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !freeze && !any_wr) |=> (t_q.sec != $past(t_q.sec))) else $error("pending tick lost"); // R12
   AST_WR_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && any_wr) |=> pend_q) else $error("tick dropped on write"); // R13

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
   import tk_pkg::*;
#(
   parameter int DIV_COUNT = 32768,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   output logic [7:0]        rd_data
);
   localparam int TIME_BASE = 4;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(TIME_BASE);
   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(TIME_BASE + TK_FIELDS - 1);
   localparam int STOP_BIT = 5;
   localparam int LOAD_BIT = 0;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("bcd_timekeeper: ADDR_W must cover the time registers");
      end
   endgenerate

   logic stop_q, load_q, osf_q, tick;
   logic [TK_FIELDS-1:0] fld_wr;
   logic [7:0] rd_mux;
   tk_time_t now;

   generate
      for (genvar i = 0; i < TK_FIELDS; i++) begin : g_fld
         assign fld_wr[i] = wr_en && (addr == ADDR_W'(TIME_BASE + i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         load_q <= 1'b0;
         osf_q  <= 1'b1;
      end else begin
         if (wr_en && addr == A_CTRL) begin
            stop_q <= wr_data[STOP_BIT];
            load_q <= wr_data[LOAD_BIT];
         end
         if (fld_wr[0]) osf_q <= wr_data[7];
      end
   end

   tk_prescaler #(.DIV_COUNT(DIV_COUNT)) u_presc (
      .clk(clk), .rst_n(rst_n), .hold_reset(stop_q), .tick(tick)
   );

   tk_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(hold),
      .fld_wr(fld_wr), .wr_data(wr_data), .now(now)
   );

   always_comb begin
      rd_mux = 8'h00;
      case (addr)
         A_CTRL:                rd_mux = {2'b00, stop_q, 4'b0000, load_q};
         ADDR_W'(TIME_BASE+0):  rd_mux = {osf_q, now.sec};
         ADDR_W'(TIME_BASE+1):  rd_mux = {1'b0, now.min};
         ADDR_W'(TIME_BASE+2):  rd_mux = {2'b00, now.hour};
         ADDR_W'(TIME_BASE+3):  rd_mux = {2'b00, now.day};
         ADDR_W'(TIME_BASE+4):  rd_mux = {5'b00000, now.wday};
         ADDR_W'(TIME_BASE+5):  rd_mux = {3'b000, now.mon};
         ADDR_W'(TIME_BASE+6):  rd_mux = now.year;
         default:               rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= 8'h00;
      else if (rd_en) rd_data <= rd_mux;
   end

   AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_SEC) |=> $stable(osf_q)) else $error("flag changed without write"); // R7
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr > A_LAST) |=> (rd_data == 8'h00)) else $error("unmapped read nonzero"); // R2
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)) else $error("read data moved"); // R3

endmodule

// File: tb/bcd_timekeeper_tb_top.sv
module bcd_timekeeper_tb_top;
   localparam int DIV = 16;

   logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0] addr = 4'h0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   int checks = 0, fails = 0;
   string tag = "R1";

   always #10 clk = ~clk;

   bcd_timekeeper #(.DIV_COUNT(DIV), .ADDR_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .hold(hold), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
   );

   // ---------------- behavioural reference model ----------------
   int m_div, m_sec, m_min, m_hour, m_day, m_wday, m_mon, m_year;
   bit m_osf, m_stop, m_load, m_pend, exp_v;
   logic [7:0] exp_d;

   function automatic int b2i(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      logic [7:0] r;
      r[7:4] = 4'(v / 10);
      r[3:0] = 4'(v % 10);
      return r;
   endfunction

   function automatic int mlen(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] mreg(input logic [3:0] a);
      case (a)
         4'd0:  return {2'b00, m_stop, 4'b0000, m_load};
         4'd4:  return {m_osf, 7'b0} | i2b(m_sec);
         4'd5:  return i2b(m_min);
         4'd6:  return i2b(m_hour);
         4'd7:  return i2b(m_day);
         4'd8:  return 8'(m_wday);
         4'd9:  return i2b(m_mon);
         4'd10: return i2b(m_year);
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_wday = 0;
         m_mon = 1; m_year = 0; m_osf = 1; m_stop = 0; m_load = 0; m_pend = 0;
         exp_v = 0;
      end else begin
         bit tk, wt;
         tk = !m_stop && (m_div == DIV - 1);
         exp_v = rd_en;
         exp_d = mreg(addr);
         wt = wr_en && addr >= 4'd4 && addr <= 4'd10;
         if (m_stop) m_div = 0; else m_div = (m_div + 1) % DIV;
         if ((tk || m_pend) && !hold && !wt) begin
            m_sec++;
            if (m_sec == 60) begin
               m_sec = 0; m_min++;
               if (m_min == 60) begin
                  m_min = 0; m_hour++;
                  if (m_hour == 24) begin
                     m_hour = 0; m_wday = (m_wday + 1) % 7; m_day++;
                     if (m_day > mlen(m_mon, m_year)) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
                     end
                  end
               end
            end
         end
         m_pend = (tk || m_pend) && (hold || wt);
         if (wr_en) begin
            case (addr)
               4'd0:  begin m_stop = wr_data[5]; m_load = wr_data[0]; end
               4'd4:  begin m_osf = wr_data[7]; m_sec = b2i(wr_data & 8'h7F); end
               4'd5:  m_min  = b2i(wr_data & 8'h7F);
               4'd6:  m_hour = b2i(wr_data & 8'h3F);
               4'd7:  m_day  = b2i(wr_data & 8'h3F);
               4'd8:  m_wday = int'(wr_data[2:0]);
               4'd9:  m_mon  = b2i(wr_data & 8'h1F);
               4'd10: m_year = b2i(wr_data);
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
      end
   endtask

   // every read is compared to the model, on the clock it returns
   always @(negedge clk) if (rst_n && exp_v) check(tag, rd_data, exp_d);

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1; wr_en = 1'b0;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         addr = 4'(i % 11); rd_en = 1'b1;
         @(negedge clk);
      end
      rd_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] s, mi, h, d, wd, mo, y);
      wr(4'd0, 8'h20);
      wr(4'd4, s); wr(4'd5, mi); wr(4'd6, h); wr(4'd7, d);
      wr(4'd8, wd); wr(4'd9, mo); wr(4'd10, y);
      wr(4'd0, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] d, s0, s1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values (read before the first tick)
      tag = "R1";
      rd(4'd4, d);  check("R1 seconds+flag", d, 8'h80);
      rd(4'd7, d);  check("R1 day", d, 8'h01);
      rd(4'd9, d);  check("R1 month", d, 8'h01);
      rd(4'd0, d);  check("R1 control", d, 8'h00);

      // R2, R3, R6 while stopped
      tag = "R2";
      wr(4'd0, 8'h21);
      wr(4'd2, 8'hFF); rd(4'd2, d); check("R2 unmapped addr 2", d, 8'h00);
      wr(4'd6, 8'hE3); rd(4'd6, d); check("R2 hour mask", d, 8'h23);
      wr(4'd9, 8'hF2); rd(4'd9, d); check("R2 month mask", d, 8'h12);
      rd(4'd11, d); check("R2 unmapped addr 11", d, 8'h00);
      rd(4'd15, d); check("R2 unmapped addr 15", d, 8'h00);
      tag = "R6";
      rd(4'd0, d); check("R6 control readback", d, 8'h21);
      wr(4'd0, 8'h20);
      check("R3 rd_data held without rd_en", rd_data, 8'h21);
      rd(4'd0, d); check("R6 load bit cleared", d, 8'h20);

      // R5/R8/R10/R11 full century rollover
      tag = "R5";
      wr(4'd0, 8'h21);
      wr(4'd4, 8'h59); wr(4'd5, 8'h59); wr(4'd6, 8'h23); wr(4'd7, 8'h31);
      wr(4'd8, 8'h06); wr(4'd9, 8'h12); wr(4'd10, 8'h99);
      idle(20);
      rd(4'd4, d); check("R5 stopped, no advance", d, 8'h59);
      wr(4'd0, 8'h01);
      idle(8);
      rd(4'd4, d); check("R5 no advance before period", d, 8'h59);
      tag = "R8";
      idle(12);
      rd(4'd4, d);  check("R8 seconds wrap", d, 8'h00);
      rd(4'd5, d);  check("R8 minutes wrap", d, 8'h00);
      rd(4'd6, d);  check("R8 hours wrap", d, 8'h00);
      rd(4'd7, d);  check("R9 day 31 wraps", d, 8'h01);
      rd(4'd8, d);  check("R10 weekday 6 to 0", d, 8'h00);
      rd(4'd9, d);  check("R11 month 12 to 01", d, 8'h01);
      rd(4'd10, d); check("R11 year 99 to 00", d, 8'h00);

      // R7 flag survives ticks
      tag = "R7";
      wr(4'd0, 8'h20);
      wr(4'd4, 8'h90);
      rd(4'd4, d); check("R7 flag set by write", d, 8'h90);
      wr(4'd0, 8'h00);
      idle(20);
      rd(4'd4, d); check("R7 flag kept over tick", d, 8'h91);

      // R9 month lengths and leap years
      tag = "R9";
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h03, 8'h02, 8'h24); idle(20);
      rd(4'd7, d); check("R9 leap Feb 28 -> 29", d, 8'h29);
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h03, 8'h02, 8'h23); idle(20);
      rd(4'd7, d); check("R9 common Feb 28 -> 01", d, 8'h01);
      rd(4'd9, d); check("R9 common Feb -> Mar", d, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h03, 8'h02, 8'h24); idle(20);
      rd(4'd7, d); check("R9 leap Feb 29 -> 01", d, 8'h01);
      set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h02, 8'h04, 8'h10); idle(20);
      rd(4'd9, d); check("R9 Apr 30 -> May", d, 8'h05);
      rd(4'd8, d); check("R10 weekday increments", d, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h15, 8'h01, 8'h01, 8'h10); idle(20);
      rd(4'd7, d); check("R9 mid month 15 -> 16", d, 8'h16);

      // R4 free-running, model checks exact advance cycles
      tag = "R4";
      idle(70);

      // R12 hold for exactly one tick period
      tag = "R12";
      hold = 1'b1;
      rd(4'd4, s0);
      idle(14);
      rd(4'd4, s1);
      hold = 1'b0;
      check("R12 seconds frozen during hold", s1, s0);
      idle(20);

      // R13 writes every cycle for one tick period
      tag = "R13";
      for (int i = 0; i < DIV; i++) wr(4'd5, 8'h30);
      idle(20);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule